// File: doc/BRIEF.md
# Level-sensitive interrupt router

This block gathers thirty-two level-sensitive interrupt lines and presents them to a processor as two interrupt request outputs. Software controls it through a small 32-bit register port with address, write enable, write data, read enable and read data. It enables individual lines and picks the output for each line. A line counts as pending for as long as its input stays high. The block has no acknowledge register, so software quiets a line by masking it.

The enable mask is never written directly. One address sets mask bits and a second address clears them, so two software agents can change different lines without a read-modify-write. The top mask bit doubles as a master switch. While it is clear, neither output can assert. A per-line route register sends each line to output 0 or output 1. The block reports the synchronized levels of all lines, and a masked pending view for each output.

The register port has no back-pressure. A write completes on the clock edge where it is presented, and a read returns its data on the edge that follows the read strobe.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the enable mask and route register are all zeros, both interrupt outputs are low, and reads of the mask, route, raw and both status offsets return zero.
- R2: A write to offset 0x34 ORs the write data into the enable mask. Mask bits whose write-data bit is 0 keep their value. A read of 0x34 returns the current mask.
- R3: A write to offset 0x38 clears every mask bit whose write-data bit is 1. Writing all ones leaves the mask zero.
- R4: Mask bit 31 is the master enable. While it is 0, both outputs are low, whatever the line levels and the other mask bits are.
- R5: Route bit n selects the output for line n: 0 selects output 0 and 1 selects output 1. The route register is written and read at offset 0x20.
- R6: A read of offset 0x00 returns the lines that are pending, enabled and routed to output 0. A read of offset 0x04 returns the same for output 1. Neither status value depends on the master enable.
- R7: A read of offset 0x30 returns the synchronized line levels, whatever the mask and master enable are.
- R8: An output stays high for as long as at least one enabled line routed to it is high and the master enable is set. It drops on the clock edge after the last such line is masked.
- R9: A read of any other offset, including 0x38, returns zero. A write to any other offset changes neither the mask nor the route register.
- R10: A line that rises, with its enable and the master enable already set, raises its output on the third rising clock edge after the change and not before. A falling line takes the same three edges to drop the output.
- R11: Read data is registered. It is updated on the rising edge where the read enable is high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Level-sensitive interrupt lines, asynchronous |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid on the edge after the strobe |
| cpu_irq | output | 2 | Interrupt requests: bit 0 is output 0, bit 1 is output 1 |

## Verification
The lines are driven with several patterns:
- Some lines high while masked. These show that raw status ignores the mask while both outputs stay low.
- One line routed to each output. This tells the routing apart from a simple OR of all lines.
- The master enable cleared while individual lines stay enabled and pending. This separates the output gate from the status registers, which are not gated.

Falling and rising edges on a single line are timed edge by edge to pin the three-edge latency. Set writes, clear writes and unmapped writes are each followed by readback, which shows that the mask only ever changes in the bits named by the write data.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int unsigned NUM_LINES   = 32;
  localparam int unsigned NUM_OUTS    = 2;
  localparam int unsigned SYNC_DEPTH  = 2;
  localparam int unsigned BUS_ADDR_W  = 8;

  // register offsets (bytes)
  localparam int unsigned OFF_PEND0   = 'h00;
  localparam int unsigned OFF_PEND1   = 'h04;
  localparam int unsigned OFF_ROUTE   = 'h20;
  localparam int unsigned OFF_LEVEL   = 'h30;
  localparam int unsigned OFF_EN_SET  = 'h34;
  localparam int unsigned OFF_EN_CLR  = 'h38;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND0,
    SEL_PEND1,
    SEL_ROUTE,
    SEL_LEVEL,
    SEL_MASK,
    SEL_CLR
  } reg_sel_e;
endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
  import lvl_irq_pkg::*;
#(
  parameter int unsigned NLINES = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NLINES-1:0] bus_wdata,
  input  logic              bus_re,
  input  logic [NLINES-1:0] level,
  input  logic [NLINES-1:0] pend0,
  input  logic [NLINES-1:0] pend1,
  output logic [NLINES-1:0] en_mask,
  output logic [NLINES-1:0] route_sel,
  output logic [NLINES-1:0] bus_rdata
);
  reg_sel_e         sel;
  logic [NLINES-1:0] rd_next;

  // address decode
  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == ADDR_W'(OFF_PEND0))  sel = SEL_PEND0;
    else if (bus_addr == ADDR_W'(OFF_PEND1))  sel = SEL_PEND1;
    else if (bus_addr == ADDR_W'(OFF_ROUTE))  sel = SEL_ROUTE;
    else if (bus_addr == ADDR_W'(OFF_LEVEL))  sel = SEL_LEVEL;
    else if (bus_addr == ADDR_W'(OFF_EN_SET)) sel = SEL_MASK;
    else if (bus_addr == ADDR_W'(OFF_EN_CLR)) sel = SEL_CLR;
  end

  // enable mask: set/clear strobes only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mask <= '0;
    end else if (bus_we) begin
      if (sel == SEL_MASK)     en_mask <= en_mask | bus_wdata;
      else if (sel == SEL_CLR) en_mask <= en_mask & ~bus_wdata;
    end
  end

  // route register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         route_sel <= '0;
    else if (bus_we && sel == SEL_ROUTE) route_sel <= bus_wdata;
  end

  // read mux
  always_comb begin
    unique case (sel)
      SEL_PEND0: rd_next = pend0;
      SEL_PEND1: rd_next = pend1;
      SEL_ROUTE: rd_next = route_sel;
      SEL_LEVEL: rd_next = level;
      SEL_MASK:  rd_next = en_mask;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/lvl_irq_route.sv
module lvl_irq_route #(
  parameter int unsigned NLINES = 32,
  parameter int unsigned NOUTS  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NLINES-1:0]            level,
  input  logic [NLINES-1:0]            en_mask,
  input  logic [NLINES-1:0]            route_sel,
  output logic [NOUTS-1:0][NLINES-1:0] pend,
  output logic [NOUTS-1:0]             irq_q
);
  localparam int unsigned MASTER = NLINES - 1;

  logic [NLINES-1:0] live;
  assign live = level & en_mask;

  for (genvar k = 0; k < NOUTS; k++) begin : g_out
    logic [NLINES-1:0] pick;
    if (k == 0) begin : g_zero
      assign pick = ~route_sel;
    end else begin : g_one
      assign pick = route_sel;
    end

    assign pend[k] = live & pick;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[k] <= 1'b0;
      else        irq_q[k] <= (|pend[k]) & en_mask[MASTER];
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int unsigned NLINES = NUM_LINES,
  parameter int unsigned ADDR_W = BUS_ADDR_W,
  parameter int unsigned SYNC_N = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_src,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NLINES-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [NLINES-1:0] bus_rdata,
  output logic [1:0]        cpu_irq
);
  localparam int unsigned NOUTS = 2;

  logic [NLINES-1:0]            level;
  logic [NLINES-1:0]            en_mask;
  logic [NLINES-1:0]            route_sel;
  logic [NOUTS-1:0][NLINES-1:0] pend;

  lvl_irq_sync #(.WIDTH(NLINES), .STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (irq_src),
    .q_sync  (level)
  );

  lvl_irq_regs #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .level     (level),
    .pend0     (pend[0]),
    .pend1     (pend[1]),
    .en_mask   (en_mask),
    .route_sel (route_sel),
    .bus_rdata (bus_rdata)
  );

  lvl_irq_route #(.NLINES(NLINES), .NOUTS(NOUTS)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (level),
    .en_mask   (en_mask),
    .route_sel (route_sel),
    .pend      (pend),
    .irq_q     (cpu_irq)
  );
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk #(
  parameter int unsigned NLINES = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [NLINES-1:0] bus_wdata,
  input logic [NLINES-1:0] level,
  input logic [NLINES-1:0] en_mask,
  input logic [NLINES-1:0] route_sel,
  input logic [1:0]        cpu_irq
);
  localparam int unsigned MASTER = NLINES - 1;
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'('h34);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'('h38);
  localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'('h20);

  // R1: reset leaves mask cleared and outputs quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (en_mask == '0 && route_sel == '0 && cpu_irq == 2'b00));

  // R2: set strobe ORs data into mask
  a_r2_set_or: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SET) |=> en_mask == ($past(en_mask) | $past(bus_wdata)));

  // R3: clear strobe removes named bits
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLR) |=> (en_mask & $past(bus_wdata)) == '0);

  // R4: master enable gates both outputs
  a_r4_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !en_mask[MASTER] |=> cpu_irq == 2'b00);

  // R5: a live line routed to output 1 raises it
  a_r5_route_one: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask[MASTER] && |(level & en_mask & route_sel)) |=> cpu_irq[1]);

  // R8: with no live line both outputs drop
  a_r8_level_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ((level & en_mask) == '0) |=> cpu_irq == 2'b00);

  // R9: writes elsewhere leave state alone
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr != A_SET && bus_addr != A_CLR && bus_addr != A_ROUTE)
      |=> ($stable(en_mask) && $stable(route_sel)));
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .level     (level),
  .en_mask   (en_mask),
  .route_sel (route_sel),
  .cpu_irq   (cpu_irq)
);

// File: tb/lvl_irq_ctrl_bench.sv
module lvl_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [1:0]  cpu_irq;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_exp;
  string       m_tag;

  always #5 clk = ~clk;

  lvl_irq_ctrl u_lvl_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  // monitor: pops expected read data once each read completes
  initial forever begin
    @(posedge clk);
    if (bus_re) begin
      #1;
      if (exp_q.size() > 0) begin
        m_exp = exp_q.pop_front();
        m_tag = tag_q.pop_front();
        n_tests++;
        if (bus_rdata !== m_exp) begin
          n_fail++;
          $display("FAIL %s rdata=%h expected=%h", m_tag, bus_rdata, m_exp);
        end
      end
    end
  end

  // driver tasks: called at a falling edge, return at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic chk_irq(input logic [1:0] e, input string tag);
    n_tests++;
    if (cpu_irq !== e) begin
      n_fail++;
      $display("FAIL %s cpu_irq=%b expected=%b", tag, cpu_irq, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_irq(2'b00, "R1 outputs after reset");
    rd(8'h34, 32'h0, "R1 mask reset");
    rd(8'h20, 32'h0, "R1 route reset");
    rd(8'h30, 32'h0, "R1 level reset");
    rd(8'h00, 32'h0, "R1 pend0 reset");
    rd(8'h04, 32'h0, "R1 pend1 reset");

    // R7 raw level ignores the mask
    irq_src = 32'h0000_0005;
    repeat (3) @(negedge clk);
    rd(8'h30, 32'h0000_0005, "R7 raw level while masked");
    chk_irq(2'b00, "R7 masked lines stay quiet");

    // R2 set strobe, R4 master still off
    wr(8'h34, 32'h0000_0001);
    @(negedge clk);
    rd(8'h34, 32'h0000_0001, "R2 mask after set");
    chk_irq(2'b00, "R4 master off blocks output");
    rd(8'h00, 32'h0000_0001, "R6 pend0 ungated by master");

    wr(8'h34, 32'h8000_0000);
    @(negedge clk);
    rd(8'h34, 32'h8000_0001, "R2 set keeps other bits");
    chk_irq(2'b01, "R6 output0 on line0");

    // R5 route line0 to output 1
    wr(8'h20, 32'h0000_0001);
    @(negedge clk);
    chk_irq(2'b10, "R5 line0 moved to output1");
    rd(8'h20, 32'h0000_0001, "R5 route readback");
    rd(8'h04, 32'h0000_0001, "R6 pend1");
    rd(8'h00, 32'h0000_0000, "R6 pend0 empty");

    wr(8'h34, 32'h0000_0004);
    @(negedge clk);
    chk_irq(2'b11, "R5 both outputs live");
    rd(8'h00, 32'h0000_0004, "R6 pend0 line2");

    // R3/R8 clearing silences a level source
    wr(8'h38, 32'h0000_0001);
    rd(8'h34, 32'h8000_0004, "R3 clear single bit");
    chk_irq(2'b01, "R8 masked line drops output1");

    // R10 falling latency
    irq_src = 32'h0000_0001;
    repeat (2) @(negedge clk);
    chk_irq(2'b01, "R10 output still high after two edges");
    @(negedge clk);
    chk_irq(2'b00, "R10 output low on third edge");

    // R10 rising latency
    irq_src = 32'h0000_0005;
    repeat (2) @(negedge clk);
    chk_irq(2'b00, "R10 output still low after two edges");
    @(negedge clk);
    chk_irq(2'b01, "R10 output high on third edge");
    chk_irq(2'b01, "R8 held while level high");

    // R4 clearing master
    wr(8'h38, 32'h8000_0000);
    @(negedge clk);
    chk_irq(2'b00, "R4 master cleared");
    rd(8'h00, 32'h0000_0004, "R6 pend0 independent of master");

    // R9 unmapped offsets
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h34, 32'h0000_0004, "R9 mask untouched by unmapped write");
    rd(8'h20, 32'h0000_0001, "R9 route untouched by unmapped write");
    rd(8'h10, 32'h0000_0000, "R9 unmapped read");
    rd(8'h38, 32'h0000_0000, "R9 clear offset reads zero");

    // R11 read data holds without strobe
    @(negedge clk);
    n_tests++;
    if (bus_rdata !== 32'h0) begin
      n_fail++;
      $display("FAIL R11 rdata hold=%h expected=%h", bus_rdata, 32'h0);
    end

    // R3 clear all
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h34, 32'h0000_0000, "R3 clear all");

    // R5 route all to output 0
    wr(8'h20, 32'h0000_0000);
    wr(8'h34, 32'h8000_0001);
    @(negedge clk);
    rd(8'h20, 32'h0000_0000, "R5 route zero");
    chk_irq(2'b01, "R5 line0 back on output0");

    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule